// File: doc/BRIEF.md
# Full-Duplex Byte Serial Slave Port

This block is the slave end of a four-wire host serial link: a serial clock, an active-low select, a data line from the host and a data line back to it. While select is low the host clocks bits in, MSB first. At the same time the block returns a reply byte that the core supplied beforehand. All host signals are sampled by a much faster system clock through synchronisers. Every action is then taken on edges detected in that domain.

When select falls, the reply byte on `reply_i` is latched and its MSB appears on the data-out line before any serial clock edge. Each later reply bit is presented after a falling serial clock edge. Once all eight reply bits have been sent, the line repeats the host's own bits, in the order they arrived. When select rises, the byte collected during the frame goes to the core. A one-cycle `rx_valid_o` pulse marks the delivery. The receive side is a stream with no back-pressure, because the host cannot be stalled, so the core must accept the byte in the cycle the pulse is high. Frames shorter than eight clocks yield a right-aligned byte. Frames longer than eight clocks yield their final eight bits.

Top module: `fdx_serial_slave`

## Requirements
- R1: After reset, `sdout_oe_o` and `rx_valid_o` are 0.
- R2: While selected, `sdin_i` is sampled on each rising `sclk_i` edge and shifted in MSB first. An 8-clock frame delivers exactly the byte that was sent.
- R3: The reply byte is latched from `reply_i` when select falls, and its MSB is on `sdout_o` before the first clock edge. Each following bit is presented after a falling `sclk_i` edge. Changes on `reply_i` after select has fallen do not affect the frame.
- R4: `sdout_oe_o` is 1 while select is low and 0 while it is high.
- R5: Each rise of select produces exactly one single-cycle `rx_valid_o` pulse, with the frame's byte on `rx_data_o` in that cycle.
- R6: A frame with N < 8 clocks delivers its N bits in the low N positions, with zeros above them. A frame with no clocks delivers 0x00.
- R7: A frame with more than 8 clocks delivers only the last 8 bits received.
- R8: After the reply LSB, each further falling clock edge puts the next received bit on `sdout_o`, beginning with the first bit of the frame.
- R9: The host signals pass through `SYNC_STAGES` flops. Correct operation requires `sclk_i` to idle low while select changes, and each serial clock phase to last at least 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssel_n_i | input | 1 | Host select, active low |
| sclk_i | input | 1 | Host serial clock |
| sdin_i | input | 1 | Serial data from host |
| sdout_o | output | 1 | Serial data to host |
| sdout_oe_o | output | 1 | Output enable for the external tri-state driver on the data-out line |
| reply_i | input | BYTE_W | Reply byte for the next frame |
| rx_valid_o | output | 1 | One-cycle strobe for the received byte |
| rx_data_o | output | BYTE_W | Received byte |

## Verification
The bench builds the block with its defaults, `BYTE_W` = 8 and `SYNC_STAGES` = 2, and runs the serial clock at eight system clocks per phase. That leaves a wide margin over the three-cycle detection delay. With these values the vector table covers frames of 0, 1, 3, 8, 12 and 16 clocks. Every frame checks the reply bits and the echo stage on the data-out line, bit by bit. Directed frames check reply latching against mid-frame changes, and the output enable both inside and outside a frame.

// File: rtl/fdx_pkg.sv
package fdx_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t detect_edge(input logic now, input logic prev);
    edge_t e;
    e.rise = now & ~prev;
    e.fall = ~now & prev;
    return e;
  endfunction
endpackage

// File: rtl/fdx_sync.sv
module fdx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[w] <= {STAGES{RST_VAL[w]}};
      else if (STAGES > 1) chain[w] <= {chain[w][STAGES-2:0], d_i[w]};
      else chain[w] <= d_i[w];
    end
    assign q_o[w] = chain[w][STAGES-1];
  end
endmodule

// File: rtl/fdx_rx_shift.sv
module fdx_rx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              deliver_i,
  output logic              last_bit_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (clear_i) sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[BYTE_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= deliver_i;
      if (deliver_i) rx_data_o <= sh_q;
    end
  end

  assign last_bit_o = sh_q[0];

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clear_i) |=> (sh_q[0] == $past(bit_i))); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sh_q == '0)); // R6
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R5
endmodule

// File: rtl/fdx_tx_shift.sv
module fdx_tx_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] reply_i,
  input  logic              echo_bit_i,
  output logic              sdout_o
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (load_i) sh_q <= reply_i;
    else if (shift_i) sh_q <= {sh_q[BYTE_W-2:0], echo_bit_i};
  end

  assign sdout_o = sh_q[BYTE_W-1];

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sdout_o == $past(reply_i[BYTE_W-1]))); // R3
  AST_ECHO_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (sh_q[0] == $past(echo_bit_i))); // R8
endmodule

// File: rtl/fdx_serial_slave.sv
module fdx_serial_slave #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ssel_n_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  output logic              sdout_oe_o,
  input  logic [BYTE_W-1:0] reply_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o
);
  import fdx_pkg::*;

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b100;

  logic [NSIG-1:0] raw, synced;
  logic ssn_s, sck_s, sdi_s;
  logic ssn_d, sck_d;
  logic oe_q;
  edge_t sel_e, sck_e;
  logic frame_start, frame_end, bit_in_en, bit_out_en;
  logic echo_bit;

  assign raw = {ssel_n_i, sclk_i, sdin_i};

  fdx_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  assign {ssn_s, sck_s, sdi_s} = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssn_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      ssn_d <= ssn_s;
      sck_d <= sck_s;
    end
  end

  assign sel_e = detect_edge(ssn_s, ssn_d);
  assign sck_e = detect_edge(sck_s, sck_d);

  assign frame_start = sel_e.fall;
  assign frame_end   = sel_e.rise;
  assign bit_in_en   = sck_e.rise & ~ssn_s;
  assign bit_out_en  = sck_e.fall & ~ssn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else if (frame_start) oe_q <= 1'b1;
    else if (frame_end) oe_q <= 1'b0;
  end

  assign sdout_oe_o = oe_q;

  fdx_rx_shift #(.BYTE_W(BYTE_W)) i_rx (
    .clk(clk), .rst_n(rst_n),
    .clear_i(frame_start), .shift_i(bit_in_en), .bit_i(sdi_s),
    .deliver_i(frame_end), .last_bit_o(echo_bit),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  fdx_tx_shift #(.BYTE_W(BYTE_W)) i_tx (
    .clk(clk), .rst_n(rst_n),
    .load_i(frame_start), .shift_i(bit_out_en), .reply_i(reply_i),
    .echo_bit_i(echo_bit), .sdout_o(sdout_o)
  );

  AST_OE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> sdout_oe_o); // R4
  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !sdout_oe_o); // R4
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> rx_valid_o); // R5
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> !rx_valid_o); // R5
endmodule

// File: tb/test_fdx_serial_slave.sv
module test_fdx_serial_slave;
  localparam int BW = 8;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ssel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_oe, rx_valid;
  logic [BW-1:0] reply = '0, rx_data;

  int errors = 0, checks = 0, strobes = 0;
  logic [BW-1:0] last_rx = '0;

  always #4 clk = ~clk;

  fdx_serial_slave #(.BYTE_W(BW), .SYNC_STAGES(2)) i_fdx_serial_slave (
    .clk(clk), .rst_n(rst_n), .ssel_n_i(ssel_n), .sclk_i(sclk), .sdin_i(sdin),
    .sdout_o(sdout), .sdout_oe_o(sdout_oe), .reply_i(reply),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      strobes = strobes + 1;
      last_rx = rx_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // fields: [36:32] clock count, [31:16] host bits (low nbits, MSB first), [15:8] reply, [7:0] expected byte
  localparam int NV = 7;
  localparam logic [36:0] VEC [NV] = '{
    {5'd8,  16'h00A5, 8'h3C, 8'hA5},
    {5'd8,  16'h005A, 8'hFF, 8'h5A},
    {5'd3,  16'h0005, 8'h81, 8'h05},
    {5'd12, 16'h0ABC, 8'h12, 8'hBC},
    {5'd16, 16'hBEEF, 8'hC3, 8'hEF},
    {5'd0,  16'h0000, 8'h77, 8'h00},
    {5'd1,  16'h0001, 8'h00, 8'h01}
  };

  task automatic frame(input int nb, input logic [15:0] mo, input logic [BW-1:0] rp,
                       input logic [BW-1:0] exp, input bit disturb);
    int s0;
    logic eb;
    s0 = strobes;
    reply = rp;
    waitc(2);
    ssel_n = 1'b0;
    waitc(H);
    chk(sdout_oe == 1'b1, "R4 oe in frame", int'(sdout_oe), 1);
    chk(sdout == rp[BW-1], "R3 first reply bit", int'(sdout), int'(rp[BW-1]));
    if (disturb) reply = ~rp;
    for (int k = 0; k < nb; k++) begin
      sdin = mo[nb-1-k];
      waitc(H);
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
      waitc(H);
      if (k + 1 < BW) begin
        eb = rp[BW-2-k];
        chk(sdout == eb, "R3 reply bit", int'(sdout), int'(eb));
      end else begin
        eb = mo[nb-1-(k+1-BW)];
        chk(sdout == eb, "R8 echo bit", int'(sdout), int'(eb));
      end
    end
    ssel_n = 1'b1;
    waitc(H);
    chk(sdout_oe == 1'b0, "R4 oe after frame", int'(sdout_oe), 0);
    chk(strobes - s0 == 1, "R5 one strobe", strobes - s0, 1);
    if (nb < BW) chk(last_rx == exp, "R6 short frame byte", int'(last_rx), int'(exp));
    else if (nb > BW) chk(last_rx == exp, "R7 long frame byte", int'(last_rx), int'(exp));
    else chk(last_rx == exp, "R2 full byte", int'(last_rx), int'(exp));
  endtask

  initial begin
    waitc(3);
    chk(sdout_oe == 1'b0, "R1 oe in reset", int'(sdout_oe), 0);
    chk(rx_valid == 1'b0, "R1 strobe in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    waitc(10);
    chk(sdout_oe == 1'b0, "R1 oe after reset", int'(sdout_oe), 0);
    chk(strobes == 0, "R1 no strobe after reset", strobes, 0);

    for (int v = 0; v < NV; v++)
      frame(int'(VEC[v][36:32]), VEC[v][31:16], VEC[v][15:8], VEC[v][7:0], 1'b0);

    // R3: reply changed after select falls must not alter the frame
    frame(8, 16'h00C6, 8'h69, 8'hC6, 1'b1);
    // R9: back-to-back frames with minimal gap still each strobe once
    frame(9, 16'h01FF, 8'h00, 8'hFF, 1'b0);
    frame(2, 16'h0002, 8'hAA, 8'h02, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule